// File: doc/BRIEF.md
# Functional Unit Issue Pool

This block models when work goes into a set of execution units and when results come out of them. It does not model the arithmetic itself. The block is fed from the head of an in-order ready queue. It sees at most one candidate operation per cycle, made up of a unit class and an instruction tag. If a unit of that class can accept work and the result-event store has room, the block accepts the operation in the same cycle. The accepted unit then stays occupied for the issue latency of its class. A result event is scheduled to fire after the operation latency of the class, and when it fires the tag goes to writeback.

There are four unit classes. The integer ALU also serves the address step of loads and stores, and the memory read and write ports are separate classes. Each class has its own unit count, its own repeat interval and its own result delay. Issue is strictly in order, but results can come back out of order. When several results are due in the same cycle, they leave one per cycle in ascending tag order.

Top module: `fu_pool`

## Requirements
- R1: After reset, no unit is occupied and no result is pending: `wb_valid` is 0 and the first valid request is accepted in its own cycle.
- R2: `req_ready` is 1 in a cycle exactly when `req_valid` is 1, some unit of class `req_class` is free and fewer than NSLOT result events are in flight. Class codes are 0 = integer ALU (also load/store address), 1 = multiplier, 2 = memory read port, 3 = memory write port.
- R3: A unit that accepts an operation in cycle t can accept another one no earlier than cycle t + ISS_LAT of its class.
- R4: An operation accepted in cycle t shows its tag on `wb_tag` with `wb_valid` = 1 in cycle t + OP_LAT of its class, unless R7 delays it.
- R5: A later-issued operation with a shorter operation latency can reach writeback before an earlier-issued one.
- R6: When the head operation is not accepted, nothing behind it is accepted. The same head stays presented until it is accepted.
- R7: Results that are due together go out one per cycle, lowest tag first. The results not yet sent stay pending and go out in later cycles.
- R8: At most NSLOT results are in flight. A full store blocks acceptance. A slot becomes free in the cycle after its result is presented.
- R9: Each class has UNITS units that are used independently, so the class can accept up to UNITS operations inside one issue-latency window. A busy class never blocks a different class.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Head of the ready queue holds an operation |
| req_class | input | CLS_W | Unit class of the head operation |
| req_tag | input | TAG_W | Instruction tag of the head operation |
| req_ready | output | 1 | Head operation is accepted this cycle |
| wb_valid | output | 1 | A result is presented to writeback |
| wb_tag | output | TAG_W | Tag of the presented result |

## Verification
The bench uses two ALUs with an issue latency of 3 and an operation latency of 1, so a third ALU operation in a row has to wait, and that exposes the unit count. The single multiplier has an issue latency of 3 and an operation latency of 4. The read port has latencies 1 and 2 and the write port 2 and 1, which makes out-of-order returns and same-cycle completions easy to set up. NSLOT is set to 3 so that a short mix of long and short operations fills the event store.

// File: rtl/fu_pool.sv
module fu_pool #(
  parameter int NCLASS = 4,
  parameter int TAG_W = 6,
  parameter int NSLOT = 3,
  parameter int UNITS [NCLASS] = '{2, 1, 1, 1},
  parameter int ISS_LAT [NCLASS] = '{3, 3, 1, 2},
  parameter int OP_LAT [NCLASS] = '{1, 4, 2, 1},
  localparam int CLS_W = (NCLASS > 1) ? $clog2(NCLASS) : 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [CLS_W-1:0] req_class,
  input  logic [TAG_W-1:0] req_tag,
  output logic             req_ready,
  output logic             wb_valid,
  output logic [TAG_W-1:0] wb_tag
);

  function automatic int max_units();
    int m = 1;
    for (int i = 0; i < NCLASS; i++) if (UNITS[i] > m) m = UNITS[i];
    return m;
  endfunction

  function automatic int max_lat();
    int m = 1;
    for (int i = 0; i < NCLASS; i++) begin
      if (ISS_LAT[i] > m) m = ISS_LAT[i];
      if (OP_LAT[i] > m) m = OP_LAT[i];
    end
    return m;
  endfunction

  localparam int MAXU = max_units();
  localparam int LW = $clog2(max_lat() + 1);
  localparam int UW = (MAXU > 1) ? $clog2(MAXU) : 1;
  localparam int SW = (NSLOT > 1) ? $clog2(NSLOT) : 1;

  logic [LW-1:0]    busy [NCLASS][MAXU];
  logic [MAXU-1:0]  free_vec [NCLASS];
  logic [MAXU-1:0]  cls_free;
  logic [UW-1:0]    unit_sel;
  logic [LW-1:0]    op_m1;

  logic             s_valid [NSLOT];
  logic [TAG_W-1:0] s_tag [NSLOT];
  logic [LW-1:0]    s_rem [NSLOT];
  logic [NSLOT-1:0] due;
  logic [NSLOT-1:0] full_vec;
  logic             have_slot;
  logic [SW-1:0]    slot_sel;
  logic [SW-1:0]    wb_sel;

  for (genvar c = 0; c < NCLASS; c++) begin : g_cls
    for (genvar u = 0; u < MAXU; u++) begin : g_unit
      if (u < UNITS[c]) begin : g_real
        assign free_vec[c][u] = (busy[c][u] == '0);
      end else begin : g_none
        assign free_vec[c][u] = 1'b0;
      end
    end
  end

  for (genvar i = 0; i < NSLOT; i++) begin : g_slot
    assign due[i] = s_valid[i] && (s_rem[i] == '0);
    assign full_vec[i] = s_valid[i];
  end

  always_comb begin
    cls_free = '0;
    op_m1 = '0;
    for (int c = 0; c < NCLASS; c++)
      if (req_class == CLS_W'(c)) begin
        cls_free = free_vec[c];
        op_m1 = LW'(OP_LAT[c] - 1);
      end
    unit_sel = '0;
    for (int u = MAXU - 1; u >= 0; u--)
      if (cls_free[u]) unit_sel = UW'(u);
  end

  always_comb begin
    have_slot = 1'b0;
    slot_sel = '0;
    for (int i = NSLOT - 1; i >= 0; i--)
      if (!s_valid[i]) begin
        have_slot = 1'b1;
        slot_sel = SW'(i);
      end
  end

  always_comb begin
    wb_valid = 1'b0;
    wb_tag = '0;
    wb_sel = '0;
    for (int i = 0; i < NSLOT; i++)
      if (due[i] && (!wb_valid || s_tag[i] < wb_tag)) begin
        wb_valid = 1'b1;
        wb_tag = s_tag[i];
        wb_sel = SW'(i);
      end
  end

  assign req_ready = req_valid && (|cls_free) && have_slot;

  always_ff @(posedge clk) begin
    for (int c = 0; c < NCLASS; c++)
      for (int u = 0; u < MAXU; u++)
        if (!rst_n)
          busy[c][u] <= '0;
        else if (req_ready && req_class == CLS_W'(c) && unit_sel == UW'(u))
          busy[c][u] <= LW'(ISS_LAT[c] - 1);
        else if (busy[c][u] != '0)
          busy[c][u] <= busy[c][u] - 1'b1;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < NSLOT; i++)
      if (!rst_n) begin
        s_valid[i] <= 1'b0;
        s_tag[i] <= '0;
        s_rem[i] <= '0;
      end else if (req_ready && slot_sel == SW'(i)) begin
        s_valid[i] <= 1'b1;
        s_tag[i] <= req_tag;
        s_rem[i] <= op_m1;
      end else if (wb_valid && wb_sel == SW'(i)) begin
        s_valid[i] <= 1'b0;
      end else if (s_valid[i] && s_rem[i] != '0) begin
        s_rem[i] <= s_rem[i] - 1'b1;
      end
  end

  a_r1_clean_start: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !wb_valid);

  a_r7_extras_held: assert property (@(posedge clk) disable iff (!rst_n)
    ($countones(due) > 1) |=> wb_valid);

  a_r8_full_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    (&full_vec && !wb_valid) |=> !req_ready);

  for (genvar c = 0; c < NCLASS; c++) begin : g_chk
    if (UNITS[c] == 1 && ISS_LAT[c] > 1) begin : g_r3
      a_r3_repeat_gap: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_class == CLS_W'(c)) |=> !(req_ready && req_class == CLS_W'(c)));
    end
    if (OP_LAT[c] > 1) begin : g_r4
      a_r4_not_early: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_class == CLS_W'(c)) |=> !(wb_valid && wb_tag == $past(req_tag)));
    end
  end

endmodule

// File: tb/fu_pool_test.sv
module fu_pool_test;
  localparam int NC = 4;
  localparam int TW = 6;
  localparam int NS = 3;
  localparam int B_UNITS [NC] = '{2, 1, 1, 1};
  localparam int B_ISS [NC] = '{3, 3, 1, 2};
  localparam int B_OP [NC] = '{1, 4, 2, 1};

  logic clk = 0;
  logic rst_n = 0;
  logic req_valid = 0;
  logic [1:0] req_class = '0;
  logic [TW-1:0] req_tag = '0;
  logic req_ready, wb_valid;
  logic [TW-1:0] wb_tag;

  fu_pool #(.NCLASS(NC), .TAG_W(TW), .NSLOT(NS), .UNITS(B_UNITS),
            .ISS_LAT(B_ISS), .OP_LAT(B_OP)) uut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_class(req_class),
    .req_tag(req_tag), .req_ready(req_ready), .wb_valid(wb_valid), .wb_tag(wb_tag));

  always #5 clk = ~clk;

  int tests = 0, fails = 0, cyc = 0, wd = 0;
  int un [NC][2];
  int q_cls [$], q_tag [$], ev_tag [$], ev_due [$];
  string cur = "R1";
  int next_tag = 0;

  task automatic check(string what, int act, int exp);
    tests++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d (cycle %0d)", cur, what, act, exp, cyc);
    end
  endtask

  task automatic step();
    bit e_rdy, e_wb;
    int e_tag, e_idx, cl;
    @(negedge clk);
    wd++;
    if (q_cls.size() > 0) begin
      req_valid = 1; req_class = 2'(q_cls[0]); req_tag = TW'(q_tag[0]);
    end else begin
      req_valid = 0; req_class = '0; req_tag = '0;
    end
    #1;
    e_rdy = 0;
    if (q_cls.size() > 0 && ev_tag.size() < NS) begin
      cl = q_cls[0];
      for (int u = 0; u < B_UNITS[cl]; u++) if (un[cl][u] <= cyc) e_rdy = 1;
    end
    e_wb = 0; e_tag = 0; e_idx = -1;
    for (int i = 0; i < ev_tag.size(); i++)
      if (ev_due[i] <= cyc && (!e_wb || ev_tag[i] < e_tag)) begin
        e_wb = 1; e_tag = ev_tag[i]; e_idx = i;
      end
    check("req_ready", int'(req_ready), int'(e_rdy));
    check("wb_valid", int'(wb_valid), int'(e_wb));
    if (e_wb) check("wb_tag", int'(wb_tag), e_tag);
    if (e_idx >= 0) begin
      ev_tag.delete(e_idx); ev_due.delete(e_idx);
    end
    if (e_rdy) begin
      cl = q_cls[0];
      for (int u = 0; u < B_UNITS[cl]; u++)
        if (un[cl][u] <= cyc) begin
          un[cl][u] = cyc + B_ISS[cl];
          break;
        end
      ev_tag.push_back(q_tag[0]); ev_due.push_back(cyc + B_OP[cl]);
      void'(q_cls.pop_front()); void'(q_tag.pop_front());
    end
    cyc++;
  endtask

  task automatic push(int cl, int tg);
    q_cls.push_back(cl); q_tag.push_back(tg);
  endtask

  task automatic push_auto(int cl);
    push(cl, next_tag); next_tag = (next_tag + 1) % (1 << TW);
  endtask

  task automatic drain(string lbl);
    cur = lbl;
    while ((q_cls.size() > 0 || ev_tag.size() > 0) && wd < 100000) step();
    repeat (4) step();
  endtask

  initial begin
    for (int c = 0; c < NC; c++) for (int u = 0; u < 2; u++) un[c][u] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    cur = "R1";
    check("wb_valid after reset", int'(wb_valid), 0);
    check("req_ready idle", int'(req_ready), 0);
    repeat (2) step();
    push(1, 1); drain("R1");
    push_auto(0); push_auto(0); push_auto(0); push_auto(0); drain("R9");
    push_auto(1); push_auto(3); push_auto(2); drain("R9");
    push_auto(1); push_auto(1); push_auto(1); drain("R3");
    push_auto(3); push_auto(3); drain("R3");
    push(0, 20); push(1, 21); push(2, 22); push(3, 23); drain("R4");
    push(1, 10); push(0, 11); drain("R5");
    push(1, 30); push(1, 31); push(3, 32); push(0, 33); drain("R6");
    push(2, 9); push(0, 3); drain("R7");
    push(1, 40); push(2, 41); push(3, 42); push(0, 43); push(0, 44); drain("R8");
    for (int k = 0; k < 400; k++) push_auto(int'($urandom_range(0, 3)));
    drain("R2");
    if (wd >= 100000) begin
      tests++; fails++;
      $display("FAIL watchdog expired actual=%0d expected<100000", wd);
    end
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #2000000;
    tests++; fails++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule